// File: doc/BRIEF.md
# 16-bit Timer with Edge Capture

This block is a 16-bit up-counter with a capture register, run in the system clock domain. It can advance on every system clock, on a one-cycle enable from a free-running divide-by-twelve prescaler, or on falling edges of an external count pin. A falling edge on a second external pin, when capture is enabled, copies the live count into a 16-bit capture register and raises an external-event flag.

A host reaches one 8-bit control register and four byte registers (count low/high, capture low/high) through a simple address/write-strobe port with a combinational read path. Two sticky flags, for count overflow and for a capture event, feed a single interrupt request. That request is gated by an enable input. Both external pins are asynchronous and are resynchronised inside the block.

Top module: `cap_timer16`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0x00 and `irq_o` is 0.
- R2: With control bits 0 (capture mode) and 2 (run) set, bit 1 (count-source select) clear and `div_sel_i` = 1, the count (address 1 low byte, address 2 high byte) rises by one every system clock.
- R3: With `div_sel_i` = 0 and bit 1 clear, the count rises once every 12 system clocks. The timing comes from a prescaler that runs freely from reset: its first pulse comes 12 cycles after reset is released, and it pulses every 12 cycles after that.
- R4: With bit 1 set, the count rises once for each falling edge of `ext_count_i`. The edge is detected after a two-flop synchroniser, so it takes effect three clock edges after the pin is sampled low.
- R5: While bit 0 or bit 2 is clear, the count holds its value unless the host writes it.
- R6: An increment from 0xFFFF to 0x0000 sets the overflow flag, control bit 7. The flag stays set until the host writes a 0 to it.
- R7: With bits 0 and 3 (capture enable) set, a synchronised falling edge on `ext_capture_i` loads the count into the capture register (address 3 low, address 4 high) and sets the external flag, control bit 6. If an increment happens in the same cycle, the register takes the count as it was before that increment. A capture also wins over a host write to the capture register in the same cycle.
- R8: While bit 3 or bit 0 is clear, edges on `ext_capture_i` leave the capture register and bit 6 unchanged.
- R9: `irq_o` is 1 exactly when `irq_en_i` is 1 and bit 7 or bit 6 is set.
- R10: A host write to a count byte takes priority over an increment in the same cycle. The other byte is kept. A write of 0x00 never sets bit 7.
- R11: Control bits 5:4 always read 0. When hardware sets a flag in the same cycle that the host writes 0 to it, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr_i | input | 3 | Register address: 0 control, 1/2 count low/high, 3/4 capture low/high |
| bus_wr_i | input | 1 | Write strobe, committed at the clock edge |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Combinational read data for `bus_addr_i` |
| div_sel_i | input | 1 | 1: timer mode counts every clock; 0: every 12 clocks |
| irq_en_i | input | 1 | Interrupt enable |
| ext_count_i | input | 1 | Asynchronous external count pin, counts on a falling edge |
| ext_capture_i | input | 1 | Asynchronous capture pin, active on a falling edge |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong count or prescaler phase shows on the count registers one clock after the faulty increment. The reference model reads those registers back every cycle, so the error is seen on the next comparison that addresses them, within five cycles. A capture that is missed, taken twice, or taken one cycle late shows as a bad capture value or a wrong bit 6, and through `irq_o` in the same cycle the flag changes. A flag that wrongly sets or fails to clear is seen at `irq_o` on the next negative clock edge.

// File: rtl/cap_timer_pkg.sv
// Shared constants for the capture timer: register addresses and
// control-bit positions. Assumes an 8-bit host data path.
package cap_timer_pkg;
    localparam int BUS_W  = 8;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL   = 3'd0,
        REG_CNT_LO = 3'd1,
        REG_CNT_HI = 3'd2,
        REG_CAP_LO = 3'd3,
        REG_CAP_HI = 3'd4
    } reg_addr_e;

    localparam int BIT_MODE = 0;  // capture mode select
    localparam int BIT_SRC  = 1;  // 1: external count pin
    localparam int BIT_RUN  = 2;
    localparam int BIT_EXEN = 3;  // capture enable
    localparam int BIT_EXF  = 6;  // capture event flag
    localparam int BIT_OVF  = 7;  // overflow flag
endpackage

// File: rtl/cap_timer_edge_sync.sv
// Resynchronises WIDTH asynchronous pins through STAGES flops each and
// produces a one-cycle pulse for every high-to-low transition.
// Assumes the pins idle high; the chain resets to 1 so reset makes no edge.
module cap_timer_edge_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] fall_o
);
    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_lane
            logic [STAGES:0] chain;

            // Shift the pin through the synchroniser plus one history flop.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-1:0], pin_i[g]};
            end

            assign fall_o[g] = chain[STAGES] & ~chain[STAGES-1];

            // R4: one accepted edge can never be counted on two consecutive clocks
            a_r4_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
                fall_o[g] |=> !fall_o[g]);
        end
    endgenerate
endmodule

// File: rtl/cap_timer_prescaler.sv
// Free-running modulo-DIV counter; tick_o is high for one cycle of every DIV.
// Assumes DIV >= 2. The counter only makes an enable; it never makes a clock.
module cap_timer_prescaler #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] phase;

    // Step the phase and wrap it at DIV-1.
    always_ff @(posedge clk) begin
        if (!rst_n)              phase <= '0;
        else if (phase == LAST)  phase <= '0;
        else                     phase <= phase + 1'b1;
    end

    assign tick_o = (phase == LAST);

    // R3: the enable never lasts longer than one cycle
    a_r3_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/cap_timer16.sv
// 16-bit timer with edge capture. Keeps the control, count and capture
// registers, picks the increment source and drives the interrupt.
// Assumes host writes are single-cycle strobes and the pins idle high.
module cap_timer16
    import cap_timer_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int PRESC_DIV = 12,
    parameter int SYNC_LEN  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_wr_i,
    input  logic [BUS_W-1:0]  bus_wdata_i,
    output logic [BUS_W-1:0]  bus_rdata_o,
    input  logic              div_sel_i,
    input  logic              irq_en_i,
    input  logic              ext_count_i,
    input  logic              ext_capture_i,
    output logic              irq_o
);
    localparam int LO_W = BUS_W;
    localparam int HI_W = CNT_W - BUS_W;

    logic [CNT_W-1:0] count_q, cap_q;
    logic ovf_q, exf_q, exen_q, run_q, src_q, mode_q;
    logic [1:0] falls;
    logic presc_tick, inc, cap_ev, ovf_set;
    logic wr_ctrl, wr_cnt_lo, wr_cnt_hi, wr_cap_lo, wr_cap_hi, wr_cnt;

    cap_timer_edge_sync #(.WIDTH(2), .STAGES(SYNC_LEN)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i ({ext_capture_i, ext_count_i}),
        .fall_o(falls)
    );

    cap_timer_prescaler #(.DIV(PRESC_DIV)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .tick_o(presc_tick)
    );

    // Decode host write strobes per register.
    always_comb begin
        wr_ctrl   = bus_wr_i && (bus_addr_i == REG_CTRL);
        wr_cnt_lo = bus_wr_i && (bus_addr_i == REG_CNT_LO);
        wr_cnt_hi = bus_wr_i && (bus_addr_i == REG_CNT_HI);
        wr_cap_lo = bus_wr_i && (bus_addr_i == REG_CAP_LO);
        wr_cap_hi = bus_wr_i && (bus_addr_i == REG_CAP_HI);
        wr_cnt    = wr_cnt_lo || wr_cnt_hi;
    end

    // Choose the increment enable and detect capture and overflow events.
    always_comb begin
        inc     = run_q && mode_q &&
                  (src_q ? falls[0] : (div_sel_i ? 1'b1 : presc_tick));
        cap_ev  = mode_q && exen_q && falls[1];
        ovf_set = inc && !wr_cnt && (count_q == '1);
    end

    // Count register: host byte writes win over increments.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (wr_cnt) begin
            if (wr_cnt_lo) count_q[LO_W-1:0]     <= bus_wdata_i;
            if (wr_cnt_hi) count_q[CNT_W-1:LO_W] <= bus_wdata_i[HI_W-1:0];
        end else if (inc) begin
            count_q <= count_q + 1'b1;
        end
    end

    // Capture register: a capture wins over a host write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else if (cap_ev) begin
            cap_q <= count_q;
        end else begin
            if (wr_cap_lo) cap_q[LO_W-1:0]     <= bus_wdata_i;
            if (wr_cap_hi) cap_q[CNT_W-1:LO_W] <= bus_wdata_i[HI_W-1:0];
        end
    end

    // Control bits: host writes them, and hardware flag sets override.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {ovf_q, exf_q, exen_q, run_q, src_q, mode_q} <= '0;
        end else begin
            if (wr_ctrl) begin
                mode_q <= bus_wdata_i[BIT_MODE];
                src_q  <= bus_wdata_i[BIT_SRC];
                run_q  <= bus_wdata_i[BIT_RUN];
                exen_q <= bus_wdata_i[BIT_EXEN];
            end
            ovf_q <= (wr_ctrl ? bus_wdata_i[BIT_OVF] : ovf_q) | ovf_set;
            exf_q <= (wr_ctrl ? bus_wdata_i[BIT_EXF] : exf_q) | cap_ev;
        end
    end

    // Return the addressed register to the host.
    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            REG_CTRL: begin
                bus_rdata_o[BIT_OVF]  = ovf_q;
                bus_rdata_o[BIT_EXF]  = exf_q;
                bus_rdata_o[BIT_EXEN] = exen_q;
                bus_rdata_o[BIT_RUN]  = run_q;
                bus_rdata_o[BIT_SRC]  = src_q;
                bus_rdata_o[BIT_MODE] = mode_q;
            end
            REG_CNT_LO: bus_rdata_o = count_q[LO_W-1:0];
            REG_CNT_HI: bus_rdata_o[HI_W-1:0] = count_q[CNT_W-1:LO_W];
            REG_CAP_LO: bus_rdata_o = cap_q[LO_W-1:0];
            REG_CAP_HI: bus_rdata_o[HI_W-1:0] = cap_q[CNT_W-1:LO_W];
            default:    bus_rdata_o = '0;
        endcase
    end

    // Combine the sticky flags into the interrupt request.
    always_comb irq_o = irq_en_i && (ovf_q || exf_q);

    // R5: a stopped counter that is not written keeps its value
    a_r5_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!(run_q && mode_q) && !wr_cnt) |=> $stable(count_q));

    // R8: capture disabled and no host write leaves the capture register alone
    a_r8_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (!(exen_q && mode_q) && !wr_cap_lo && !wr_cap_hi) |=> $stable(cap_q));

    // R7: the captured value is the count held before the edge's clock
    a_r7_cap_value: assert property (@(posedge clk) disable iff (!rst_n)
        falls[1] && mode_q && exen_q |=> (cap_q == $past(count_q)) && exf_q);

    // R6: overflow rises only from a wrap or an explicit host set
    a_r6_ovf_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_q) |-> ($past(wr_ctrl) && $past(bus_wdata_i[BIT_OVF])) ||
                         ($past(count_q) == '1 && !$past(wr_cnt)));

    // R10: a low-byte write lands even when an increment was due
    a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt_lo |=> count_q[LO_W-1:0] == $past(bus_wdata_i));
endmodule

// File: tb/cap_timer16_tb_top.sv
module cap_timer16_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       div_sel = 1'b1;
    logic       irq_en = 1'b0;
    logic       cnt_pin = 1'b1;
    logic       cap_pin = 1'b1;
    logic       irq;

    int    n_checks = 0;
    int    n_fail = 0;
    string cur_req = "R1";
    bit    comparing = 1'b0;
    bit    done = 1'b0;

    // reference model state
    int m_pc, m_cnt, m_cap;
    bit m_ovf, m_exf, m_en, m_run, m_src, m_mode;
    bit c1, c2, c3, k1, k2, k3;

    always #10 clk = ~clk;

    cap_timer16 dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr_i(bus_addr), .bus_wr_i(bus_wr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .div_sel_i(div_sel),
        .irq_en_i(irq_en), .ext_count_i(cnt_pin), .ext_capture_i(cap_pin),
        .irq_o(irq)
    );

    // Behavioural model advanced on each rising edge from the bench inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pc = 0; m_cnt = 0; m_cap = 0;
            {m_ovf, m_exf, m_en, m_run, m_src, m_mode} = '0;
            {c1, c2, c3, k1, k2, k3} = '1;
        end else begin
            bit cfall, kfall, tick, inc, cap_ev, wcnt, ovf_set;
            int old;
            cfall = c3 && !c2;
            kfall = k3 && !k2;
            tick  = (m_pc == 11);
            inc   = m_run && m_mode && (m_src ? cfall : (div_sel ? 1'b1 : tick));
            cap_ev = m_mode && m_en && kfall;
            wcnt  = bus_wr && (bus_addr == 3'd1 || bus_addr == 3'd2);
            ovf_set = inc && !wcnt && (m_cnt == 65535);
            old = m_cnt;
            if (bus_wr && bus_addr == 3'd1) m_cnt = (m_cnt & 'hFF00) | bus_wdata;
            else if (bus_wr && bus_addr == 3'd2) m_cnt = (m_cnt & 'h00FF) | (bus_wdata << 8);
            else if (inc) m_cnt = (m_cnt + 1) % 65536;
            if (cap_ev) m_cap = old;
            else if (bus_wr && bus_addr == 3'd3) m_cap = (m_cap & 'hFF00) | bus_wdata;
            else if (bus_wr && bus_addr == 3'd4) m_cap = (m_cap & 'h00FF) | (bus_wdata << 8);
            if (bus_wr && bus_addr == 3'd0) begin
                m_mode = bus_wdata[0]; m_src = bus_wdata[1];
                m_run = bus_wdata[2]; m_en = bus_wdata[3];
                m_exf = bus_wdata[6]; m_ovf = bus_wdata[7];
            end
            m_ovf = m_ovf | ovf_set;
            m_exf = m_exf | cap_ev;
            c3 = c2; c2 = c1; c1 = cnt_pin;
            k3 = k2; k2 = k1; k1 = cap_pin;
            m_pc = (m_pc == 11) ? 0 : m_pc + 1;
        end
    end

    function automatic logic [7:0] model_read(input logic [2:0] a);
        case (a)
            3'd0: return {m_ovf, m_exf, 2'b00, m_en, m_run, m_src, m_mode};
            3'd1: return m_cnt[7:0];
            3'd2: return m_cnt[15:8];
            3'd3: return m_cap[7:0];
            3'd4: return m_cap[15:8];
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare read data and interrupt against the model on every falling edge.
    always @(negedge clk) begin
        if (comparing && !done) begin
            check(cur_req, $sformatf("rdata[addr %0d]", bus_addr), bus_rdata, model_read(bus_addr));
            check(cur_req, "irq_o (R9)", irq, irq_en && (m_ovf || m_exf));
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
            bus_addr = 3'((bus_addr + 1) % 5);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #2;
        bus_wr = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        comparing = 1'b1;
        // R1: reset values on every register
        cur_req = "R1";
        for (int a = 0; a < 5; a++) begin
            bus_addr = 3'(a); #1;
            check("R1", $sformatf("reset addr %0d", a), bus_rdata, 0);
        end
        check("R1", "reset irq", irq, 0);
        idle(6);
        // R2: count every clock
        cur_req = "R2";
        div_sel = 1'b1;
        wr(3'd0, 8'h05);
        idle(40);
        // R5: stop by run bit, then by mode bit
        cur_req = "R5";
        wr(3'd0, 8'h01); idle(10);
        wr(3'd0, 8'h04); idle(10);
        // R3: prescaled counting
        cur_req = "R3";
        div_sel = 1'b0;
        wr(3'd0, 8'h05);
        idle(80);
        // R6 and R9: wrap with the interrupt enabled
        cur_req = "R6";
        irq_en = 1'b1; div_sel = 1'b1;
        wr(3'd2, 8'hFF); wr(3'd1, 8'hF0);
        idle(30);
        cur_req = "R9";
        irq_en = 1'b0; idle(4);
        irq_en = 1'b1;
        wr(3'd0, 8'h05); idle(5);
        // R4: external edges of varied width
        cur_req = "R4";
        wr(3'd0, 8'h07);
        for (int i = 0; i < 20; i++) begin
            cnt_pin = 1'b0; idle(1 + i % 3);
            cnt_pin = 1'b1; idle(1 + (i + 1) % 3);
        end
        idle(6);
        // R8: capture disabled
        cur_req = "R8";
        for (int i = 0; i < 4; i++) begin
            cap_pin = 1'b0; idle(3); cap_pin = 1'b1; idle(3);
        end
        wr(3'd0, 8'h0C); // capture enabled, mode clear
        cap_pin = 1'b0; idle(4); cap_pin = 1'b1; idle(4);
        // R7: capture while counting every clock, then in external mode
        cur_req = "R7";
        wr(3'd0, 8'h0D);
        for (int i = 0; i < 3; i++) begin
            cap_pin = 1'b0; idle(2 + i); cap_pin = 1'b1; idle(5);
        end
        wr(3'd0, 8'h0F);
        cnt_pin = 1'b0; cap_pin = 1'b0; idle(4);
        cnt_pin = 1'b1; cap_pin = 1'b1; idle(6);
        wr(3'd4, 8'h12); idle(3);
        // R10: write priority and write of zero at the wrap point
        cur_req = "R10";
        wr(3'd0, 8'h01);
        wr(3'd2, 8'hFF); wr(3'd1, 8'hFF);
        wr(3'd0, 8'h05);
        wr(3'd1, 8'h00);
        wr(3'd2, 8'h00);
        idle(8);
        wr(3'd1, 8'h80); idle(4);
        // R11: reserved bits and set-over-clear
        cur_req = "R11";
        wr(3'd0, 8'hFF); idle(5);
        wr(3'd0, 8'h0D);
        cap_pin = 1'b0; idle(2);
        wr(3'd0, 8'h0D); // clear lands near the capture edge
        idle(1); cap_pin = 1'b1; idle(6);
        wr(3'd0, 8'h00); idle(5);
        finish_run();
    end
endmodule